// File: doc/BRIEF.md
# Reset Sequencer with Power-Up and Oscillator Start-Up Timers

This block merges the reset sources of a small processor into one chip reset. The sources are a supply-good level from an analog trip detector, an active-low external reset pin and a watchdog time-out pulse. Reset is held until the start-up timers that apply to the event have run out. The power-up timer counts ticks of an internal RC clock. The oscillator start-up timer counts ticks of the crystal clock, and it runs only for the two crystal-driven oscillator modes. Both clocks reach the block as single-cycle tick enables on one system clock, so the whole sequencer is synchronous. The pin and the supply-good level each pass through a two-flop synchroniser.

A watchdog time-out while the core sleeps is treated as a wake. It never asserts the register reset. The core clock is still held in its first phase while the crystal settles. Two status bits record the cause of the last event, and a one-cycle pulse marks the end of a wake. While chip reset is active in external-execution mode, the bus strobes are forced to safe levels.

Top module: `rst_seq_top`

## Requirements
- R1: When the supply-good level rises, `chip_rst` asserts with cause code {`tmo_flag`,`pdn_flag`} = 00. It stays asserted while `ext_rst_n` is low.
- R2: After a power-up, once both the supply and the pin are high, `chip_rst` stays asserted until exactly `PWRT_TC` `rc_tick` pulses have been counted. The counter never passes `PWRT_TC`.
- R3: After the power-up timer expires, the oscillator timer also has to count `OST_TC` `xtal_tick` pulses, but only when `osc_mode` is 00 (low-frequency crystal) or 01 (crystal). Modes 10 and 11 release right after the power-up timer.
- R4: When `ext_rst_n` goes low in normal operation, `chip_rst` is held while the pin is low. It releases a few cycles after the pin goes high, with no timer wait. The cause code is 01.
- R5: A `wdt_timeout` pulse while not sleeping asserts `chip_rst` for one cycle. The cause code is 10.
- R6: A `wdt_timeout` pulse while `sleeping` is high never asserts `chip_rst`, and it sets cause code 11. In crystal modes `phase_hold` stays high until `OST_TC` crystal ticks have passed. A single one-cycle `wake_o` pulse marks the end of the wake.
- R7: `phase_hold` is high whenever `chip_rst` is high, and also during a wake's oscillator wait.
- R8: While `chip_rst` and `ext_exec` are both high, `ale_o`=0, `oe_n_o`=1 and `wr_n_o`=1. Otherwise the three outputs copy the core strobes.
- R9: With `fall_por_en`=1, a drop of `pwr_good` asserts `chip_rst` (cause 00) until the supply returns, and then the full power-up sequence runs. With `fall_por_en`=0 the drop has no effect on `chip_rst`, and the later rise starts a power-up.
- R10: When `ext_rst_n` goes low while `sleeping` is high, the result is a pin reset (`chip_rst` high, cause 01), not a wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| logic_rst_n | input | 1 | Asynchronous bring-up reset of the sequencer's own flops |
| pwr_good | input | 1 | Supply-above-trip level from the analog detector |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wdt_timeout | input | 1 | Watchdog time-out pulse |
| sleeping | input | 1 | Core is in sleep |
| osc_mode | input | 2 | Oscillator mode: 00 LF crystal, 01 crystal, 10 high-speed, 11 RC |
| fall_por_en | input | 1 | Also reset on a falling supply |
| ext_exec | input | 1 | Processor mode fetches from the external bus |
| rc_tick | input | 1 | One-cycle tick of the internal RC clock |
| xtal_tick | input | 1 | One-cycle tick of the crystal clock |
| core_ale | input | 1 | Address-latch strobe from the core |
| core_oe_n | input | 1 | Output-enable strobe from the core, active low |
| core_wr_n | input | 1 | Write strobe from the core, active low |
| chip_rst | output | 1 | Register reset for the chip |
| phase_hold | output | 1 | Freeze the four-phase clock in its first phase |
| ale_o | output | 1 | Address-latch strobe to the pins |
| oe_n_o | output | 1 | Output-enable strobe to the pins |
| wr_n_o | output | 1 | Write strobe to the pins |
| wake_o | output | 1 | One-cycle pulse at the end of a watchdog wake |
| tmo_flag | output | 1 | Cause code high bit (watchdog involved) |
| pdn_flag | output | 1 | Cause code low bit |

## Verification
The assertions check cycle-local rules on every clock:
- each accepted event sets the right reset level and cause code on the next cycle;
- a wake never raises the register reset, and `wake_o` never lasts two cycles;
- the timer counters step by one and never pass their terminal counts;
- the bus strobes sit at their safe levels during reset.

Only the directed scenarios can show the behaviour that spans many cycles:
- the exact number of ticks each timer needs;
- whether the oscillator timer is used or skipped for each mode;
- the effect of the falling-supply option;
- that a pin reset during sleep wins over the wake path.

// File: rtl/rst_seq_pkg.sv
`timescale 1ns/1ps
package rst_seq_pkg;

  typedef enum logic [2:0] {
    S_SUPPLY   = 3'd0,
    S_WAIT_PIN = 3'd1,
    S_PWRT     = 3'd2,
    S_OST      = 3'd3,
    S_PIN      = 3'd4,
    S_WDT      = 3'd5,
    S_RUN      = 3'd6
  } seq_state_e;

  typedef enum logic [1:0] {
    CAUSE_POR  = 2'b00,
    CAUSE_PIN  = 2'b01,
    CAUSE_WDT  = 2'b10,
    CAUSE_WAKE = 2'b11
  } cause_e;

  // Oscillator modes that need a crystal settle time.
  function automatic logic uses_crystal(input logic [1:0] mode);
    return (mode == 2'b00) || (mode == 2'b01);
  endfunction

  // Register reset is withheld only during a wake's settle wait.
  function automatic logic reset_level(input seq_state_e st, input logic wake_ctx);
    return (st != S_RUN) && !((st == S_OST) && wake_ctx);
  endfunction

endpackage

// File: rtl/rst_seq_sync.sv
`timescale 1ns/1ps
module rst_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[LAST-1:0], d};
      end
    end
  endgenerate

  assign q = chain[LAST];
endmodule

// File: rtl/rst_seq_timer.sv
`timescale 1ns/1ps
module rst_seq_timer #(
  parameter int CNT_W = 10,
  parameter int TERM  = 1023
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic done
);
  localparam logic [CNT_W-1:0] TERM_C = CNT_W'(TERM);

  logic [CNT_W-1:0] cnt;

  function automatic logic [CNT_W-1:0] advance(input logic [CNT_W-1:0] c, input logic t);
    return t ? c + 1'b1 : c;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (!run)  cnt <= '0;
    else if (!done) cnt <= advance(cnt, tick);
  end

  assign done = run && (cnt == TERM_C);

  // R2: the counter stops at its terminal count
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= TERM_C);

  // R2: while running, the count only ever steps by one
  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && (cnt != $past(cnt))) |-> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/rst_seq_ctrl.sv
`timescale 1ns/1ps
module rst_seq_ctrl
  import rst_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pg_s,
  input  logic       pin_s,
  input  logic       wdt,
  input  logic       sleeping,
  input  logic       fall_en,
  input  logic       crystal,
  input  logic       pwrt_done,
  input  logic       ost_done,
  output logic       pwrt_run,
  output logic       ost_run,
  output logic       chip_rst,
  output logic       phase_hold,
  output logic       wake_o,
  output logic [1:0] cause
);
  seq_state_e st, st_n;
  cause_e     cause_q, cause_n;
  logic       wake_ctx, wctx_n;
  logic       wake_q, wake_n;
  logic       pg_prev;

  // Named events, in priority order
  logic ev_por_rise, ev_fall, por_any, ev_pin, ev_wdt, ev_wake;

  assign ev_por_rise = pg_s && !pg_prev;
  assign ev_fall     = !pg_s && fall_en;
  assign por_any     = ev_por_rise || ev_fall;
  assign ev_pin      = !por_any && !pin_s &&
                       ((st == S_RUN) || ((st == S_OST) && wake_ctx));
  assign ev_wdt      = !por_any && pin_s && (st == S_RUN) && wdt && !sleeping;
  assign ev_wake     = !por_any && pin_s && (st == S_RUN) && wdt && sleeping;

  always_comb begin
    st_n    = st;
    cause_n = cause_q;
    wctx_n  = wake_ctx;
    wake_n  = 1'b0;
    if (ev_por_rise) begin
      st_n = S_WAIT_PIN; cause_n = CAUSE_POR; wctx_n = 1'b0;
    end else if (ev_fall) begin
      st_n = S_SUPPLY;   cause_n = CAUSE_POR; wctx_n = 1'b0;
    end else begin
      unique case (st)
        S_SUPPLY:   st_n = S_SUPPLY;
        S_WAIT_PIN: if (pin_s) st_n = S_PWRT;
        S_PWRT: begin
          if (!pin_s)         st_n = S_WAIT_PIN;
          else if (pwrt_done) st_n = crystal ? S_OST : S_RUN;
        end
        S_OST: begin
          if (!pin_s) begin
            if (wake_ctx) begin
              st_n = S_PIN; cause_n = CAUSE_PIN; wctx_n = 1'b0;
            end else begin
              st_n = S_WAIT_PIN;
            end
          end else if (ost_done) begin
            st_n = S_RUN; wake_n = wake_ctx; wctx_n = 1'b0;
          end
        end
        S_PIN: if (pin_s) st_n = S_RUN;
        S_WDT: st_n = S_RUN;
        S_RUN: begin
          if (!pin_s) begin
            st_n = S_PIN; cause_n = CAUSE_PIN;
          end else if (wdt && sleeping) begin
            cause_n = CAUSE_WAKE;
            if (crystal) begin
              st_n = S_OST; wctx_n = 1'b1;
            end else begin
              wake_n = 1'b1;
            end
          end else if (wdt) begin
            st_n = S_WDT; cause_n = CAUSE_WDT;
          end
        end
        default: st_n = S_SUPPLY;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_SUPPLY;
      cause_q  <= CAUSE_POR;
      wake_ctx <= 1'b0;
      wake_q   <= 1'b0;
      pg_prev  <= 1'b0;
    end else begin
      st       <= st_n;
      cause_q  <= cause_n;
      wake_ctx <= wctx_n;
      wake_q   <= wake_n;
      pg_prev  <= pg_s;
    end
  end

  assign pwrt_run   = (st == S_PWRT);
  assign ost_run    = (st == S_OST);
  assign chip_rst   = reset_level(st, wake_ctx);
  assign phase_hold = (st != S_RUN);
  assign wake_o     = wake_q;
  assign cause      = cause_q;

  p_por_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_por_rise |=> (chip_rst && (cause == 2'b00)));

  p_pwrt_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pwrt_run && !pwrt_done) |=> chip_rst);

  p_pin_resets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pin |=> (chip_rst && (cause == 2'b01)));

  p_wdt_resets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wdt |=> (chip_rst && (cause == 2'b10)));

  p_wake_no_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wake |=> (!chip_rst && (cause == 2'b11)));

  p_wake_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> !wake_o);

  p_fall_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fall |=> chip_rst);
endmodule

// File: rtl/rst_seq_bus_guard.sv
`timescale 1ns/1ps
module rst_seq_bus_guard (
  input  logic hold,
  input  logic ext_exec,
  input  logic core_ale,
  input  logic core_oe_n,
  input  logic core_wr_n,
  output logic ale_o,
  output logic oe_n_o,
  output logic wr_n_o
);
  logic force_safe;

  assign force_safe = hold && ext_exec;
  assign ale_o      = force_safe ? 1'b0 : core_ale;
  assign oe_n_o     = force_safe ? 1'b1 : core_oe_n;
  assign wr_n_o     = force_safe ? 1'b1 : core_wr_n;
endmodule

// File: rtl/rst_seq_top.sv
`timescale 1ns/1ps
module rst_seq_top
  import rst_seq_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int PWRT_TC     = 1023,
  parameter int OST_TC      = 1023,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       logic_rst_n,
  input  logic       pwr_good,
  input  logic       ext_rst_n,
  input  logic       wdt_timeout,
  input  logic       sleeping,
  input  logic [1:0] osc_mode,
  input  logic       fall_por_en,
  input  logic       ext_exec,
  input  logic       rc_tick,
  input  logic       xtal_tick,
  input  logic       core_ale,
  input  logic       core_oe_n,
  input  logic       core_wr_n,
  output logic       chip_rst,
  output logic       phase_hold,
  output logic       ale_o,
  output logic       oe_n_o,
  output logic       wr_n_o,
  output logic       wake_o,
  output logic       tmo_flag,
  output logic       pdn_flag
);
  logic       pg_s, pin_s;
  logic       pwrt_run, ost_run, pwrt_done, ost_done;
  logic       crystal;
  logic [1:0] cause;

  assign crystal = uses_crystal(osc_mode);

  rst_seq_sync #(.STAGES(SYNC_STAGES)) u_sync_pg (
    .clk(clk), .rst_n(logic_rst_n), .d(pwr_good), .q(pg_s));

  rst_seq_sync #(.STAGES(SYNC_STAGES)) u_sync_pin (
    .clk(clk), .rst_n(logic_rst_n), .d(ext_rst_n), .q(pin_s));

  rst_seq_timer #(.CNT_W(CNT_W), .TERM(PWRT_TC)) u_pwrt (
    .clk(clk), .rst_n(logic_rst_n), .run(pwrt_run), .tick(rc_tick), .done(pwrt_done));

  rst_seq_timer #(.CNT_W(CNT_W), .TERM(OST_TC)) u_ost (
    .clk(clk), .rst_n(logic_rst_n), .run(ost_run), .tick(xtal_tick), .done(ost_done));

  rst_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(logic_rst_n), .pg_s(pg_s), .pin_s(pin_s),
    .wdt(wdt_timeout), .sleeping(sleeping), .fall_en(fall_por_en),
    .crystal(crystal), .pwrt_done(pwrt_done), .ost_done(ost_done),
    .pwrt_run(pwrt_run), .ost_run(ost_run), .chip_rst(chip_rst),
    .phase_hold(phase_hold), .wake_o(wake_o), .cause(cause));

  rst_seq_bus_guard u_guard (
    .hold(chip_rst), .ext_exec(ext_exec), .core_ale(core_ale),
    .core_oe_n(core_oe_n), .core_wr_n(core_wr_n),
    .ale_o(ale_o), .oe_n_o(oe_n_o), .wr_n_o(wr_n_o));

  assign tmo_flag = cause[1];
  assign pdn_flag = cause[0];

  // R8: strobes at safe levels during reset in external-execution mode
  p_bus_safe_r8: assert property (@(posedge clk) disable iff (!logic_rst_n)
    (chip_rst && ext_exec) |-> (!ale_o && oe_n_o && wr_n_o));

  // R7: the phase clock is frozen whenever registers are in reset
  p_hold_covers_reset_r7: assert property (@(posedge clk) disable iff (!logic_rst_n)
    chip_rst |-> phase_hold);

  // R3: no crystal wait is ever entered in a non-crystal mode
  p_ost_mode_r3: assert property (@(posedge clk) disable iff (!logic_rst_n)
    $rose(ost_run) |-> $past(crystal));
endmodule

// File: tb/rst_seq_top_tb_top.sv
`timescale 1ns/1ps
module rst_seq_top_tb_top;
  localparam int TC = 8;

  logic clk = 1'b0;
  logic logic_rst_n, pwr_good, ext_rst_n, wdt_timeout, sleeping;
  logic [1:0] osc_mode;
  logic fall_por_en, ext_exec, rc_tick, xtal_tick;
  logic core_ale, core_oe_n, core_wr_n;
  logic chip_rst, phase_hold, ale_o, oe_n_o, wr_n_o, wake_o, tmo_flag, pdn_flag;

  int n_chk  = 0;
  int n_fail = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  rst_seq_top #(.CNT_W(10), .PWRT_TC(TC), .OST_TC(TC), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .logic_rst_n(logic_rst_n), .pwr_good(pwr_good), .ext_rst_n(ext_rst_n),
    .wdt_timeout(wdt_timeout), .sleeping(sleeping), .osc_mode(osc_mode),
    .fall_por_en(fall_por_en), .ext_exec(ext_exec), .rc_tick(rc_tick),
    .xtal_tick(xtal_tick), .core_ale(core_ale), .core_oe_n(core_oe_n),
    .core_wr_n(core_wr_n), .chip_rst(chip_rst), .phase_hold(phase_hold),
    .ale_o(ale_o), .oe_n_o(oe_n_o), .wr_n_o(wr_n_o), .wake_o(wake_o),
    .tmo_flag(tmo_flag), .pdn_flag(pdn_flag));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rc_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      rc_tick = 1'b1; @(negedge clk);
      rc_tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic xt_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      xtal_tick = 1'b1; @(negedge clk);
      xtal_tick = 1'b0; @(negedge clk);
    end
  endtask

  // Runs the timers of a power-up and checks the release point.
  task automatic timers_to_release(input bit crystal, input string tag);
    idle(6);
    rc_pulses(TC - 1);
    idle(6);
    chk({tag, " R2 held one tick short"}, chip_rst, 1);
    rc_pulses(1);
    idle(4);
    if (crystal) begin
      chk({tag, " R3 held for crystal"}, chip_rst, 1);
      xt_pulses(TC - 1);
      idle(6);
      chk({tag, " R3 held one crystal tick short"}, chip_rst, 1);
      xt_pulses(1);
      idle(4);
    end
    chk({tag, " R2/R3 released"}, chip_rst, 0);
    chk({tag, " R7 hold released"}, phase_hold, 0);
  endtask

  task automatic t_power_on();
    logic_rst_n = 1'b0; pwr_good = 1'b0; ext_rst_n = 1'b0; wdt_timeout = 1'b0;
    sleeping = 1'b0; osc_mode = 2'b10; fall_por_en = 1'b0; ext_exec = 1'b1;
    rc_tick = 1'b0; xtal_tick = 1'b0;
    core_ale = 1'b1; core_oe_n = 1'b0; core_wr_n = 1'b0;
    idle(3);
    logic_rst_n = 1'b1;
    idle(2);
    chk("R1 reset state chip_rst", chip_rst, 1);
    chk("R7 reset state phase_hold", phase_hold, 1);
    chk("R1 reset state cause", {tmo_flag, pdn_flag}, 2'b00);
    chk("R8 safe strobes", {ale_o, oe_n_o, wr_n_o}, 3'b011);
    pwr_good = 1'b1;
    idle(10);
    chk("R1 held while pin low", chip_rst, 1);
    rc_pulses(TC + 2);
    chk("R1 ticks ignored while pin low", chip_rst, 1);
    ext_rst_n = 1'b1;
    timers_to_release(1'b0, "por-rc");
    chk("R8 strobes pass through", {ale_o, oe_n_o, wr_n_o}, 3'b100);
  endtask

  task automatic t_pin_reset();
    ext_rst_n = 1'b0;
    idle(4);
    chk("R4 pin reset asserted", chip_rst, 1);
    chk("R4 pin cause", {tmo_flag, pdn_flag}, 2'b01);
    chk("R8 safe strobes in pin reset", {ale_o, oe_n_o, wr_n_o}, 3'b011);
    idle(20);
    chk("R4 still held while low", chip_rst, 1);
    ext_exec = 1'b0;
    idle(1);
    chk("R8 no forcing outside ext exec", {ale_o, oe_n_o, wr_n_o}, 3'b100);
    ext_exec = 1'b1;
    ext_rst_n = 1'b1;
    idle(5);
    chk("R4 released without timers", chip_rst, 0);
  endtask

  task automatic t_wdt_reset();
    sleeping = 1'b0;
    wdt_timeout = 1'b1;
    @(negedge clk);
    wdt_timeout = 1'b0;
    chk("R5 wdt reset asserted", chip_rst, 1);
    chk("R5 wdt cause", {tmo_flag, pdn_flag}, 2'b10);
    idle(2);
    chk("R5 wdt reset released", chip_rst, 0);
  endtask

  task automatic t_wake_rc();
    sleeping = 1'b1; osc_mode = 2'b11;
    idle(1);
    wdt_timeout = 1'b1;
    @(negedge clk);
    wdt_timeout = 1'b0;
    chk("R6 wake pulse rc mode", wake_o, 1);
    chk("R6 no reset on wake", chip_rst, 0);
    chk("R6 wake cause", {tmo_flag, pdn_flag}, 2'b11);
    @(negedge clk);
    chk("R6 wake pulse one cycle", wake_o, 0);
    sleeping = 1'b0;
  endtask

  task automatic t_wake_xtal();
    int pulses = 0;
    bit saw_rst = 0;
    sleeping = 1'b1; osc_mode = 2'b01;
    idle(1);
    wdt_timeout = 1'b1;
    @(negedge clk);
    wdt_timeout = 1'b0;
    chk("R7 phase held during crystal wake", phase_hold, 1);
    chk("R6 no reset during crystal wake", chip_rst, 0);
    for (int i = 0; i < 2 * (TC - 1) + 6; i++) begin
      if (chip_rst) saw_rst = 1;
      if (i < 2 * (TC - 1)) begin
        xtal_tick = (i % 2 == 0); @(negedge clk);
      end else begin
        xtal_tick = 1'b0; @(negedge clk);
      end
    end
    chk("R6 held one crystal tick short", phase_hold, 1);
    xt_pulses(1);
    for (int i = 0; i < 5; i++) begin
      if (chip_rst) saw_rst = 1;
      if (wake_o) pulses++;
      @(negedge clk);
    end
    chk("R6 one wake pulse", pulses, 1);
    chk("R6 no reset seen during wake", saw_rst, 0);
    chk("R6 phase hold released", phase_hold, 0);
    sleeping = 1'b0;
  endtask

  task automatic t_pin_in_sleep();
    sleeping = 1'b1;
    ext_rst_n = 1'b0;
    idle(4);
    chk("R10 pin in sleep resets", chip_rst, 1);
    chk("R10 pin in sleep cause", {tmo_flag, pdn_flag}, 2'b01);
    ext_rst_n = 1'b1;
    idle(5);
    chk("R10 released", chip_rst, 0);
    sleeping = 1'b0;
  endtask

  task automatic t_fall_ignored();
    fall_por_en = 1'b0; osc_mode = 2'b10;
    pwr_good = 1'b0;
    idle(8);
    chk("R9 falling supply ignored", chip_rst, 0);
    pwr_good = 1'b1;
    idle(4);
    chk("R9 rise restarts power-up", chip_rst, 1);
    chk("R9 rise cause", {tmo_flag, pdn_flag}, 2'b00);
    timers_to_release(1'b0, "rise-only");
  endtask

  task automatic t_fall_resets();
    fall_por_en = 1'b1; osc_mode = 2'b00;
    pwr_good = 1'b0;
    idle(4);
    chk("R9 falling supply resets", chip_rst, 1);
    chk("R9 fall cause", {tmo_flag, pdn_flag}, 2'b00);
    rc_pulses(TC + 2);
    chk("R9 held while supply low", chip_rst, 1);
    pwr_good = 1'b1;
    timers_to_release(1'b1, "fall-lf");
    fall_por_en = 1'b0;
  endtask

  task automatic report();
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    t_power_on();
    t_pin_reset();
    t_wdt_reset();
    t_wake_rc();
    t_wake_xtal();
    t_pin_in_sleep();
    t_fall_ignored();
    t_fall_resets();
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    report();
  end
endmodule